// File: doc/BRIEF.md
# Satellite Tone Generator and Selector

This block turns a fast converter clock into a square signalling tone at one twentieth of that clock's rate. A 22 kHz tone therefore needs a 440 kHz converter clock. It also decides which tone source drives the output-modulation control. Two register bits, applied here as plain inputs, choose among three sources. The first is a tone that runs continuously. The second is the internal tone switched on and off by an external modulation pin, which is used for burst and bit-level coding. The third is an externally modulated tone taken from that pin and passed through unchanged.

The modulation pin is asynchronous, so it passes through a synchroniser before any logic uses it. In the pin-gated source, the gate opens and closes only at the boundary between tone periods. Each burst therefore holds whole tone periods, with no shortened half-cycles at either end. Both outputs are registered. A converter clock enable tells downstream logic when the divider is running.

Top module: `tone_select_top`

## Requirements
- R1: While `rst` is high at a rising edge, `tone_gate` and `conv_en` are 0 after that edge. The divider count is cleared, so in continuous mode the first tone period after reset begins high at the first edge with `rst` low.
- R2: In continuous mode the tone repeats every 20 clocks. Counting edges from 1 after reset release, `tone_gate` is 1 after edges 1 to 10 and 0 after edges 11 to 20 of each period.
- R3: When `reg_tone_on` = 1, `tone_gate` does not depend on `mod_pin`.
- R4: When `reg_tone_on` = 0 and `reg_ext_sel` = 0, `tone_gate` carries the internal tone only during tone periods whose gate is open, and is 0 in all other periods.
- R5: In the pin-gated mode, once `mod_pin` has been low for at least 22 clocks, `tone_gate` stays 0 for as long as the pin remains low.
- R6: When `reg_tone_on` = 0 and `reg_ext_sel` = 1, `tone_gate` after edge n equals `mod_pin` as sampled at edge n-2. This covers a two-stage synchroniser and one output register.
- R7: `conv_en` is 1 after every rising edge at which `rst` is low.
- R8: `reg_tone_on` = 1 takes priority over `reg_ext_sel`, so the continuous tone is produced when both bits are 1.
- R9: The gate state for a tone period is the synchronised pin value at the last clock of the previous period. A pin change in the middle of a period does not alter that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, running at 20 times the tone rate |
| rst | input | 1 | Synchronous active-high reset |
| reg_tone_on | input | 1 | Register bit that forces the continuous tone |
| reg_ext_sel | input | 1 | Register bit: 1 passes the external modulated tone through, 0 uses the pin as a gate |
| mod_pin | input | 1 | Asynchronous external modulation pin |
| tone_gate | output | 1 | Registered tone that drives output modulation |
| conv_en | output | 1 | Converter clock enable, high while the divider runs |

## Verification
A wrong divider count shows at the ports within one tone period, as a shifted or uneven square wave in continuous mode. A gate state that is wrong, or that changes in the middle of a period, appears on the next edge in pin-gated mode as a runt pulse or as a burst that starts one period early or late. A synchroniser of the wrong depth shifts the external pass-through by one clock, and this is visible three edges after any pin change. The bench drives random mode changes and random pin toggles alongside directed bursts. It compares every cycle against a reference model that applies the requirements.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        TM_CONT  = 2'd0,
        TM_GATED = 2'd1,
        TM_PASS  = 2'd2
    } tone_mode_e;

    typedef struct packed {
        logic sq;
        logic last;
    } div_state_t;

    function automatic tone_mode_e pick_mode(input logic force_on, input logic ext_sel);
        if (force_on)
            return TM_CONT;
        else if (ext_sel)
            return TM_PASS;
        else
            return TM_GATED;
    endfunction

    function automatic int unsigned half_of(input int unsigned div);
        return div / 2;
    endfunction

endpackage

// File: rtl/tone_div.sv
module tone_div
    import tone_pkg::*;
#(
    parameter int unsigned DIV = 20,
    parameter int unsigned CW  = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output div_state_t    st
);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(half_of(DIV));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        st.sq   = (cnt < HALF);
        st.last = (cnt == LAST);
    end
endmodule

// File: rtl/tone_sync.sv
module tone_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tone_gate_ctl.sv
module tone_gate_ctl
    import tone_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  div_state_t st,
    input  logic       pin_s,
    output logic       gate_open
);
    always_ff @(posedge clk) begin
        if (rst)
            gate_open <= 1'b0;
        else if (st.last)
            gate_open <= pin_s;
    end
endmodule

// File: rtl/tone_out.sv
module tone_out
    import tone_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tone_mode_e mode,
    input  div_state_t st,
    input  logic       gate_open,
    input  logic       pin_s,
    output logic       tone_gate,
    output logic       conv_en
);
    logic nxt;

    always_comb begin
        case (mode)
            TM_CONT:  nxt = st.sq;
            TM_GATED: nxt = gate_open & st.sq;
            TM_PASS:  nxt = pin_s;
            default:  nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tone_gate <= 1'b0;
            conv_en   <= 1'b0;
        end else begin
            tone_gate <= nxt;
            conv_en   <= 1'b1;
        end
    end
endmodule

// File: rtl/tone_select_top.sv
module tone_select_top
    import tone_pkg::*;
#(
    parameter int unsigned DIV         = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic reg_tone_on,
    input  logic reg_ext_sel,
    input  logic mod_pin,
    output logic tone_gate,
    output logic conv_en
);
    localparam int unsigned CW = $clog2(DIV);

    logic [CW-1:0] div_cnt;
    div_state_t    div_st;
    logic          pin_sync;
    logic          gate_open;
    tone_mode_e    mode;

    assign mode = pick_mode(reg_tone_on, reg_ext_sel);

    tone_div #(.DIV(DIV), .CW(CW)) u_div (
        .clk (clk),
        .rst (rst),
        .cnt (div_cnt),
        .st  (div_st)
    );

    tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (mod_pin),
        .dout (pin_sync)
    );

    tone_gate_ctl u_gate (
        .clk       (clk),
        .rst       (rst),
        .st        (div_st),
        .pin_s     (pin_sync),
        .gate_open (gate_open)
    );

    tone_out u_out (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .st        (div_st),
        .gate_open (gate_open),
        .pin_s     (pin_sync),
        .tone_gate (tone_gate),
        .conv_en   (conv_en)
    );
endmodule

// File: rtl/tone_select_chk.sv
module tone_select_chk #(
    parameter int unsigned DIV = 20,
    parameter int unsigned CW  = $clog2(DIV)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_tone_on,
    input logic          reg_ext_sel,
    input logic          tone_gate,
    input logic          conv_en,
    input logic [CW-1:0] cnt,
    input logic          pin_s,
    input logic          gate_open
);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic started;
    logic rst_d;
    logic sq_ref;

    assign sq_ref = (cnt < HALF);

    always_ff @(posedge clk) begin
        started <= 1'b1;
        rst_d   <= rst;
        if (started === 1'b1 && rst_d === 1'b1) begin
            a_r1_reset_low: assert (!tone_gate && !conv_en)
                else $error("a_r1_reset_low");
        end
    end

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> (cnt == '0));

    a_r2_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    a_r3_r8_continuous: assert property (@(posedge clk) disable iff (rst)
        reg_tone_on |=> (tone_gate == $past(sq_ref)));

    a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
        (!reg_tone_on && reg_ext_sel) |=> (tone_gate == $past(pin_s)));

    a_r9_gate_holds: assert property (@(posedge clk) disable iff (rst)
        (cnt != LAST) |=> $stable(gate_open));

    a_r4_closed_silent: assert property (@(posedge clk) disable iff (rst)
        (!reg_tone_on && !reg_ext_sel && !gate_open) |=> !tone_gate);

    a_r7_enable_on: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> conv_en);
endmodule

bind tone_select_top tone_select_chk #(.DIV(DIV), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_tone_on (reg_tone_on),
    .reg_ext_sel (reg_ext_sel),
    .tone_gate   (tone_gate),
    .conv_en     (conv_en),
    .cnt         (div_cnt),
    .pin_s       (pin_sync),
    .gate_open   (gate_open)
);

// File: tb/tb_tone_select_top.sv
module tb_tone_select_top;
    localparam int DIV  = 20;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_tone_on = 1'b0;
    logic reg_ext_sel = 1'b0;
    logic mod_pin = 1'b0;
    logic tone_gate;
    logic conv_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tone_select_top dut (
        .clk         (clk),
        .rst         (rst),
        .reg_tone_on (reg_tone_on),
        .reg_ext_sel (reg_ext_sel),
        .mod_pin     (mod_pin),
        .tone_gate   (tone_gate),
        .conv_en     (conv_en)
    );

    // reference model built from the requirements
    int m_cnt = 0;
    bit m_s1 = 0, m_s2 = 0, m_g = 0, m_tone = 0, m_ce = 0;

    function automatic bit sq_of(input int c);
        return c < HALF;
    endfunction

    function automatic bit next_tone(input bit on, input bit ext, input int c,
                                     input bit g, input bit s2);
        if (on) return sq_of(c);
        if (ext) return s2;
        return g & sq_of(c);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_s1 = 0; m_s2 = 0; m_g = 0; m_tone = 0; m_ce = 0;
        end else begin
            m_tone = next_tone(reg_tone_on, reg_ext_sel, m_cnt, m_g, m_s2);
            if (m_cnt == DIV - 1) m_g = m_s2;
            m_s2 = m_s1;
            m_s1 = mod_pin;
            m_cnt = (m_cnt + 1) % DIV;
            m_ce = 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_cycle();
        string tag;
        if (rst) tag = "R1";
        else if (reg_tone_on) tag = reg_ext_sel ? "R8" : "R3";
        else if (reg_ext_sel) tag = "R6";
        else tag = "R4/R9";
        check(tone_gate === m_tone, tag, int'(tone_gate), int'(m_tone));
        check(conv_en === m_ce, rst ? "R1" : "R7", int'(conv_en), int'(m_ce));
    endtask

    task automatic step();
        @(negedge clk);
        cmp_cycle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            step();
            check(tone_gate === 1'b0 && conv_en === 1'b0, "R1",
                  int'({tone_gate, conv_en}), 0);
        end
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20241));
        // R1 / R2: reset, then continuous tone shape
        reg_tone_on = 1'b1;
        do_reset(3);
        for (int k = 1; k <= 3 * DIV; k++) begin
            mod_pin = k[2];                      // toggling pin must not matter (R3)
            step();
            check(tone_gate === sq_of((k - 1) % DIV), "R2",
                  int'(tone_gate), int'(sq_of((k - 1) % DIV)));
        end

        // R8: both bits high still gives continuous tone
        reg_ext_sel = 1'b1;
        begin
            int highs = 0;
            for (int k = 0; k < 2 * DIV; k++) begin
                mod_pin = ~mod_pin;
                step();
                if (tone_gate) highs++;
            end
            check(highs == 2 * HALF, "R8", highs, 2 * HALF);
        end

        // R4 / R9: gated burst, pin rises mid-period
        reg_tone_on = 1'b0; reg_ext_sel = 1'b0; mod_pin = 1'b0;
        do_reset(2);
        repeat (5) step();
        mod_pin = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 14; k++) begin
                step();
                if (tone_gate) seen++;
            end
            check(seen == 0, "R9", seen, 0);
        end
        repeat (3 * DIV) step();

        // R5: pin low, tone dies out and stays off
        mod_pin = 1'b0;
        repeat (DIV + 2) step();
        begin
            int seen = 0;
            for (int k = 0; k < 3 * DIV; k++) begin
                step();
                if (tone_gate) seen++;
            end
            check(seen == 0, "R5", seen, 0);
        end

        // R6: pass-through latency
        reg_ext_sel = 1'b1;
        repeat (4) step();
        mod_pin = 1'b1;
        step(); step();
        check(tone_gate === 1'b0, "R6", int'(tone_gate), 0);
        step();
        check(tone_gate === 1'b1, "R6", int'(tone_gate), 1);

        // random mix of modes and pin activity
        for (int seg = 0; seg < 60; seg++) begin
            int len = 20 + int'($urandom_range(180));
            int pm  = int'($urandom_range(3));
            reg_tone_on = ($urandom_range(3) == 0);
            reg_ext_sel = $urandom_range(1);
            if (seg % 17 == 16) do_reset(1 + int'($urandom_range(3)));
            for (int k = 0; k < len; k++) begin
                if (pm == 0) mod_pin = $urandom_range(1);
                else if ($urandom_range(15) == 0) mod_pin = ~mod_pin;
                step();
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule